// File: doc/BRIEF.md
# Programmable Product-Term Plane with Linear Fuse Store

This block is the logic core of a small programmable-logic cell. It holds a configuration store of 2706 one-bit fuses and evaluates a plane of 64 wide AND gates (product terms) over 20 input signals. Each input feeds two literal columns, its true and its complement, which gives 40 columns. A fuse that reads 0 connects its column into its term, and a fuse that reads 1 leaves the column out. Each term also has a separate kill fuse that forces it to 0 whatever its AND fuses hold. The 64 term values leave the block in eight groups of eight, one group for each downstream output cell. The per-cell and global architecture bits are decoded from the store and presented next to them.

Configuration uses one flat fuse number space. A write port loads a single fuse at a time. A bulk-clear command returns every fuse to 1. A combinational read port returns any fuse, including a 64-bit identification area that has no effect on the logic. The store is built from flops and is reset to the cleared state, so a block that was never programmed drives every term high.

Top module: `pterm_array`

## Requirements
- R1: After reset every fuse reads 1. All 64 terms are 1, every cell polarity bit, cell I/O-select bit and both global mode bits are 1, and rdData returns 1 for every address from 0 to 2705.
- R2: Input i drives literal column 2i with its true value and column 2i+1 with its complement.
- R3: A term is the AND of the literal columns whose fuse is 0. A term with no connected column is 1, and a term with both columns of one input connected is 0 for either value of that input.
- R4: The AND fuse for term t and column k has address t*40+k (addresses 0 to 2559). termOut bit t carries term t, so cell c receives bits 8c to 8c+7.
- R5: The kill fuse of term t is at address 2640+t. When it is 0, term t is 0 regardless of its AND fuses. When it is 1, the term follows its AND fuses.
- R6: Fuse 2560+c drives cellPolarity[c] and fuse 2632+c drives cellIoSel[c], for c from 0 to 7. Fuse 2704 drives globalModeSel[0] and fuse 2705 drives globalModeSel[1].
- R7: Fuses 2568 to 2631 form an identification area. They can be written and read back, and they change no term and no architecture output.
- R8: A write with wrEn high stores wrData at fuse wrAddr on the rising clock edge. Its effect on termOut, on the architecture outputs and on rdData is visible right after that edge. rdData follows rdAddr combinationally.
- R9: eraseAll sets every fuse to 1 on the rising edge. When wrEn is high in the same cycle, eraseAll wins and the write is dropped.
- R10: A write to an address at or above 2706 changes no fuse, and a read at such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all fuse updates happen on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset to the cleared fuse state |
| sigIn | input | 20 | Logic inputs to the product-term plane |
| wrEn | input | 1 | Single-fuse write strobe |
| wrAddr | input | 12 | Fuse number for the write |
| wrData | input | 1 | Value to store at wrAddr |
| eraseAll | input | 1 | Bulk clear of every fuse to 1; takes priority over wrEn |
| rdAddr | input | 12 | Fuse number for read-back |
| rdData | output | 1 | Stored value at rdAddr, 0 when out of range |
| termOut | output | 64 | Product-term values, eight per output cell |
| cellPolarity | output | 8 | Per-cell polarity architecture bits |
| cellIoSel | output | 8 | Per-cell I/O-select architecture bits |
| globalModeSel | output | 2 | Global mode architecture bits |

## Verification
The hard case to reach is a term that evaluates to 1 while many of its literals are connected. Random fuse writes almost always leave such a term at 0. To reach it, the stimulus clears a term's row, picks a random input vector and connects, for most inputs, the literal that the vector satisfies. It then applies that exact vector, which must give a 1, and a copy with one connected input flipped, which must give a 0. Bulk clear arriving together with a write, kill fuses on terms whose AND row is fully open, and writes into the identification area and beyond the top of the map are driven as directed cases.

// File: rtl/pta_pkg.sv
`timescale 1ns/1ps
package pta_pkg;

  // Strobes from the command decoder to the fuse store
  typedef struct packed {
    logic clearAll;   // return every fuse to 1
    logic loadBit;    // store one bit at the decoded address
  } fuseCmd_t;

endpackage

// File: rtl/pta_ctrl.sv
`timescale 1ns/1ps
module pta_ctrl
  import pta_pkg::*;
#(
  parameter int FUSE_COUNT = 2706,
  parameter int ADDR_W     = 12
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              eraseAll,
  output fuseCmd_t          fuseCmd
);

  logic addrInMap;

  assign addrInMap = (wrAddr < ADDR_W'(FUSE_COUNT));

  // Bulk clear outranks a single-bit load in the same cycle
  always_comb begin
    fuseCmd.clearAll = eraseAll;
    fuseCmd.loadBit  = wrEn && addrInMap && !eraseAll;
  end

endmodule

// File: rtl/pta_fuse_store.sv
`timescale 1ns/1ps
module pta_fuse_store
  import pta_pkg::*;
#(
  parameter int TERM_COUNT = 64,
  parameter int COL_COUNT  = 40,
  parameter int CELL_COUNT = 8,
  parameter int SIG_BITS   = 64,
  parameter int ADDR_W     = 12
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  fuseCmd_t                        fuseCmd,
  input  logic [ADDR_W-1:0]               wrAddr,
  input  logic                            wrData,
  input  logic [ADDR_W-1:0]               rdAddr,
  output logic                            rdData,
  output logic [TERM_COUNT*COL_COUNT-1:0] andFuses,
  output logic [TERM_COUNT-1:0]           killFuses,
  output logic [CELL_COUNT-1:0]           polFuses,
  output logic [CELL_COUNT-1:0]           ioFuses,
  output logic [1:0]                      globFuses
);

  localparam int AND_FUSES  = TERM_COUNT * COL_COUNT;
  localparam int POL_BASE   = AND_FUSES;
  localparam int SIG_BASE   = POL_BASE + CELL_COUNT;
  localparam int IOSEL_BASE = SIG_BASE + SIG_BITS;
  localparam int KILL_BASE  = IOSEL_BASE + CELL_COUNT;
  localparam int GLOB_BASE  = KILL_BASE + TERM_COUNT;
  localparam int FUSE_COUNT = GLOB_BASE + 2;

  logic [FUSE_COUNT-1:0] fuseBits;

  // Cleared state (all ones) is the reset state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fuseBits <= '1;
    end else if (fuseCmd.clearAll) begin
      fuseBits <= '1;
    end else if (fuseCmd.loadBit) begin
      fuseBits[wrAddr] <= wrData;
    end
  end

  always_comb begin
    if (rdAddr < ADDR_W'(FUSE_COUNT)) rdData = fuseBits[rdAddr];
    else                             rdData = 1'b0;
  end

  assign andFuses  = fuseBits[AND_FUSES-1:0];
  assign polFuses  = fuseBits[POL_BASE +: CELL_COUNT];
  assign ioFuses   = fuseBits[IOSEL_BASE +: CELL_COUNT];
  assign killFuses = fuseBits[KILL_BASE +: TERM_COUNT];
  assign globFuses = fuseBits[GLOB_BASE +: 2];

endmodule

// File: rtl/pta_and_plane.sv
`timescale 1ns/1ps
module pta_and_plane #(
  parameter int IN_COUNT   = 20,
  parameter int TERM_COUNT = 64,
  parameter int COL_COUNT  = 2 * IN_COUNT
) (
  input  logic [IN_COUNT-1:0]             sigIn,
  input  logic [TERM_COUNT*COL_COUNT-1:0] andFuses,
  input  logic [TERM_COUNT-1:0]           killFuses,
  output logic [TERM_COUNT-1:0]           termOut
);

  logic [COL_COUNT-1:0] litVec;

  // Even column: true literal, odd column: complement
  for (genvar i = 0; i < IN_COUNT; i++) begin : g_lit
    assign litVec[2*i]   = sigIn[i];
    assign litVec[2*i+1] = ~sigIn[i];
  end

  // A fuse at 1 masks its column out of the AND
  for (genvar t = 0; t < TERM_COUNT; t++) begin : g_term
    assign termOut[t] = killFuses[t] &
                        (&(litVec | andFuses[t*COL_COUNT +: COL_COUNT]));
  end

endmodule

// File: rtl/pterm_array.sv
`timescale 1ns/1ps
module pterm_array
  import pta_pkg::*;
#(
  parameter int IN_COUNT       = 20,
  parameter int TERM_COUNT     = 64,
  parameter int TERMS_PER_CELL = 8,
  parameter int SIG_BITS       = 64,
  localparam int COL_COUNT     = 2 * IN_COUNT,
  localparam int CELL_COUNT    = TERM_COUNT / TERMS_PER_CELL,
  localparam int FUSE_COUNT    = TERM_COUNT * COL_COUNT + 2 * CELL_COUNT
                                 + SIG_BITS + TERM_COUNT + 2,
  localparam int ADDR_W        = $clog2(FUSE_COUNT)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IN_COUNT-1:0]   sigIn,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic                  wrData,
  input  logic                  eraseAll,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic                  rdData,
  output logic [TERM_COUNT-1:0] termOut,
  output logic [CELL_COUNT-1:0] cellPolarity,
  output logic [CELL_COUNT-1:0] cellIoSel,
  output logic [1:0]            globalModeSel
);

  fuseCmd_t                        fuseCmd;
  logic [TERM_COUNT*COL_COUNT-1:0] andFuses;
  logic [TERM_COUNT-1:0]           killFuses;

  pta_ctrl #(
    .FUSE_COUNT (FUSE_COUNT),
    .ADDR_W     (ADDR_W)
  ) ctrl_i (
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .eraseAll (eraseAll),
    .fuseCmd  (fuseCmd)
  );

  pta_fuse_store #(
    .TERM_COUNT (TERM_COUNT),
    .COL_COUNT  (COL_COUNT),
    .CELL_COUNT (CELL_COUNT),
    .SIG_BITS   (SIG_BITS),
    .ADDR_W     (ADDR_W)
  ) store_i (
    .clk       (clk),
    .rstN      (rstN),
    .fuseCmd   (fuseCmd),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .andFuses  (andFuses),
    .killFuses (killFuses),
    .polFuses  (cellPolarity),
    .ioFuses   (cellIoSel),
    .globFuses (globalModeSel)
  );

  pta_and_plane #(
    .IN_COUNT   (IN_COUNT),
    .TERM_COUNT (TERM_COUNT),
    .COL_COUNT  (COL_COUNT)
  ) plane_i (
    .sigIn     (sigIn),
    .andFuses  (andFuses),
    .killFuses (killFuses),
    .termOut   (termOut)
  );

endmodule

// File: rtl/pterm_array_chk.sv
`timescale 1ns/1ps
module pterm_array_chk #(
  parameter int IN_COUNT       = 20,
  parameter int TERM_COUNT     = 64,
  parameter int TERMS_PER_CELL = 8,
  parameter int SIG_BITS       = 64,
  localparam int COL_COUNT     = 2 * IN_COUNT,
  localparam int CELL_COUNT    = TERM_COUNT / TERMS_PER_CELL,
  localparam int FUSE_COUNT    = TERM_COUNT * COL_COUNT + 2 * CELL_COUNT
                                 + SIG_BITS + TERM_COUNT + 2,
  localparam int ADDR_W        = $clog2(FUSE_COUNT)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     wrAddr,
  input logic                  wrData,
  input logic                  eraseAll,
  input logic [ADDR_W-1:0]     rdAddr,
  input logic                  rdData,
  input logic [TERM_COUNT-1:0] termOut,
  input logic [CELL_COUNT-1:0] cellPolarity,
  input logic [CELL_COUNT-1:0] cellIoSel,
  input logic [1:0]            globalModeSel
);

  localparam int SIG_BASE  = TERM_COUNT * COL_COUNT + CELL_COUNT;
  localparam int KILL_BASE = SIG_BASE + SIG_BITS + CELL_COUNT;
  localparam int GLOB_BASE = KILL_BASE + TERM_COUNT;
  localparam int TIDX_W    = $clog2(TERM_COUNT);

  logic              killHit;
  logic [TIDX_W-1:0] killIdx;
  logic              plainWr;

  assign plainWr = wrEn && !eraseAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      killHit <= 1'b0;
      killIdx <= '0;
    end else begin
      killHit <= plainWr && !wrData &&
                 (wrAddr >= ADDR_W'(KILL_BASE)) && (wrAddr < ADDR_W'(GLOB_BASE));
      killIdx <= TIDX_W'(wrAddr - ADDR_W'(KILL_BASE));
    end
  end

  // R9: bulk clear leaves every term and architecture bit at 1
  p_clear_all_r9: assert property (@(posedge clk) disable iff (!rstN)
    eraseAll |=> (&termOut && &cellPolarity && &cellIoSel && &globalModeSel));

  // R6: global mode bit 0 takes the written value
  p_global_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (plainWr && wrAddr == ADDR_W'(GLOB_BASE)) |=> (globalModeSel[0] == $past(wrData)));

  // R5: a kill fuse written to 0 forces its term low
  p_kill_term_r5: assert property (@(posedge clk) disable iff (!rstN)
    killHit |-> (termOut[killIdx] == 1'b0));

  // R7: identification fuses leave architecture outputs alone
  p_ident_inert_r7: assert property (@(posedge clk) disable iff (!rstN)
    (plainWr && wrAddr >= ADDR_W'(SIG_BASE) && wrAddr < ADDR_W'(SIG_BASE + SIG_BITS))
    |=> ($stable(cellPolarity) && $stable(cellIoSel) && $stable(globalModeSel)));

  // R10: writes past the map change nothing visible
  p_oob_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (plainWr && wrAddr >= ADDR_W'(FUSE_COUNT))
    |=> ($stable(cellPolarity) && $stable(cellIoSel) && $stable(globalModeSel)));

  // R10: reads past the map return 0
  p_oob_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr >= ADDR_W'(FUSE_COUNT)) |-> (rdData == 1'b0));

endmodule

bind pterm_array pterm_array_chk #(
  .IN_COUNT       (IN_COUNT),
  .TERM_COUNT     (TERM_COUNT),
  .TERMS_PER_CELL (TERMS_PER_CELL),
  .SIG_BITS       (SIG_BITS)
) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .wrEn          (wrEn),
  .wrAddr        (wrAddr),
  .wrData        (wrData),
  .eraseAll      (eraseAll),
  .rdAddr        (rdAddr),
  .rdData        (rdData),
  .termOut       (termOut),
  .cellPolarity  (cellPolarity),
  .cellIoSel     (cellIoSel),
  .globalModeSel (globalModeSel)
);

// File: tb/pterm_array_tb_top.sv
`timescale 1ns/1ps
module pterm_array_tb_top;

  localparam int NF   = 2706;
  localparam int NT   = 64;
  localparam int NI   = 20;
  localparam int NCOL = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] sigIn = '0;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic        wrData = 1'b0;
  logic        eraseAll = 1'b0;
  logic [11:0] rdAddr = '0;
  logic        rdData;
  logic [63:0] termOut;
  logic [7:0]  cellPolarity;
  logic [7:0]  cellIoSel;
  logic [1:0]  globalModeSel;

  logic [NF-1:0] refFuse;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pterm_array dut_i (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .eraseAll(eraseAll), .rdAddr(rdAddr), .rdData(rdData),
    .termOut(termOut), .cellPolarity(cellPolarity), .cellIoSel(cellIoSel),
    .globalModeSel(globalModeSel)
  );

  function automatic logic [63:0] expTerms(input logic [19:0] s);
    logic [63:0] r;
    for (int t = 0; t < NT; t++) begin
      r[t] = refFuse[2640 + t];
      for (int i = 0; i < NI; i++) begin
        if (!refFuse[t*NCOL + 2*i]     && !s[i]) r[t] = 1'b0;
        if (!refFuse[t*NCOL + 2*i + 1] &&  s[i]) r[t] = 1'b0;
      end
    end
    return r;
  endfunction

  function automatic logic [17:0] expArch();
    logic [17:0] a;
    for (int c = 0; c < 8; c++) begin
      a[c]     = refFuse[2560 + c];
      a[8 + c] = refFuse[2632 + c];
    end
    a[16] = refFuse[2704];
    a[17] = refFuse[2705];
    return a;
  endfunction

  task automatic report(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic checkOuts(input string tag);
    #1;
    report(tag, termOut, expTerms(sigIn));
    report(tag, {46'd0, globalModeSel, cellIoSel, cellPolarity}, {46'd0, expArch()});
  endtask

  task automatic checkRead(input string tag, input int addr);
    logic expBit;
    rdAddr = 12'(addr);
    #1;
    expBit = (addr < NF) ? refFuse[addr] : 1'b0;
    report(tag, {63'd0, rdData}, {63'd0, expBit});
  endtask

  task automatic putFuse(input int addr, input logic d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 12'(addr); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (addr < NF) refFuse[addr] = d;
  endtask

  task automatic clearWithWrite(input int addr, input logic d);
    @(negedge clk);
    eraseAll = 1'b1; wrEn = 1'b1; wrAddr = 12'(addr); wrData = d;
    @(negedge clk);
    eraseAll = 1'b0; wrEn = 1'b0;
    refFuse = '1;
  endtask

  task automatic setInputs(input logic [19:0] v);
    @(negedge clk);
    sigIn = v;
  endtask

  initial begin
    refFuse = '1;
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkOuts("R1");
    checkRead("R1", 0);
    checkRead("R1", 1234);
    checkRead("R1", 2705);
    checkRead("R10", 2706);

    // R2 R4: true literal of input 3 into term 5 (column 6 -> 5*40+6)
    putFuse(5*NCOL + 6, 1'b0);
    setInputs(20'h00008); checkOuts("R2");
    setInputs(20'h00000); checkOuts("R2");
    checkRead("R8", 5*NCOL + 6);
    // R3: complement column too -> always 0
    putFuse(5*NCOL + 7, 1'b0);
    setInputs(20'h00008); checkOuts("R3");
    setInputs(20'hFFFF7); checkOuts("R3");
    // R4: last term, last column (complement of input 19)
    putFuse(63*NCOL + 39, 1'b0);
    setInputs(20'h80000); checkOuts("R4");
    setInputs(20'h7FFFF); checkOuts("R4");

    // R5: kill a term with open row, then restore
    putFuse(2640 + 9, 1'b0);  checkOuts("R5");
    putFuse(2640 + 9, 1'b1);  checkOuts("R5");
    putFuse(2640 + 63, 1'b0); checkOuts("R5");

    // R6: architecture bits
    putFuse(2560 + 2, 1'b0); checkOuts("R6");
    putFuse(2632 + 7, 1'b0); checkOuts("R6");
    putFuse(2704, 1'b0);     checkOuts("R6");
    putFuse(2705, 1'b0);     checkOuts("R6");

    // R7: identification area
    for (int k = 0; k < 64; k += 7) begin
      putFuse(2568 + k, 1'(k & 1));
      checkRead("R7", 2568 + k);
      checkOuts("R7");
    end

    // R10: writes past the map
    putFuse(2706, 1'b0); checkOuts("R10"); checkRead("R10", 2706);
    putFuse(4095, 1'b0); checkOuts("R10"); checkRead("R10", 4095);

    // R9: bulk clear beats a simultaneous write
    clearWithWrite(0, 1'b0);
    checkOuts("R9");
    checkRead("R9", 0);
    checkRead("R9", 2704);

    // R3 R8: rows built to match a chosen vector, plus random extras
    for (int it = 0; it < 48; it++) begin
      int t;
      logic [19:0] v;
      int flipIn;
      t = int'($urandom_range(NT - 1));
      v = 20'($urandom);
      flipIn = -1;
      for (int k = 0; k < NCOL; k++) putFuse(t*NCOL + k, 1'b1);
      putFuse(2640 + t, 1'b1);
      for (int i = 0; i < NI; i++) begin
        if ($urandom_range(3) != 0) begin
          putFuse(t*NCOL + 2*i + (v[i] ? 0 : 1), 1'b0);
          flipIn = i;
        end
      end
      setInputs(v); checkOuts("R3");
      if (flipIn >= 0) begin
        setInputs(v ^ (20'd1 << flipIn)); checkOuts("R3");
      end
      putFuse(int'($urandom_range(2559)), 1'($urandom));
      if ($urandom_range(3) == 0) putFuse(2640 + int'($urandom_range(NT - 1)), 1'($urandom));
      if ($urandom_range(3) == 0) putFuse(2568 + int'($urandom_range(63)), 1'($urandom));
      setInputs(20'($urandom)); checkOuts("R8");
      checkRead("R8", int'($urandom_range(4095)));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule